// File: doc/BRIEF.md
# Multi-width aliased register file

This block holds the general-purpose data registers of a processor core. Software can reach them at byte, word, doubleword and quadword width. A mode input chooses between two register sets. Legacy mode has eight 32-bit registers and wide mode has sixteen 64-bit registers. A per-port prefix flag controls how byte accesses to register numbers 4 to 7 are decoded. Without the flag they reach the second byte of registers 0 to 3. With the flag they reach the low byte of registers 4 to 7.

The block has two read ports and one write port. Each port carries a 4-bit register number, a 2-bit operand size and the prefix flag. Reads are combinational and zero-extended to 64 bits. A write takes effect on the rising clock edge. A 32-bit write clears the upper half of the register. A narrower write merges into the value already held. A separate flags register has its own write strobe and read bus. Its upper 32 bits accept writes but always read as zero.

A forbidden access is refused and flagged in the same cycle. This covers the prefix flag in legacy mode, a register number of 8 or more in legacy mode, and a 64-bit access in legacy mode. None of the ports has back-pressure. A read is always answered in its own cycle, and a write with `wr_en` high is always taken at the next edge. The plain control and status pins therefore carry no valid/ready handshake.

Top module: `regfile_alias`

## Requirements
- R1: A synchronous reset clears every data register and the flags register to zero. All of them read as zero in the cycle after reset.
- R2: In wide mode (`mode_wide`=1), registers 0 to 15 are each 64 bits. A 64-bit access is size code 3, and a 64-bit write followed by a 64-bit read of the same register returns the written value.
- R3: A 32-bit write (size code 2) stores data bits 31:0 and clears bits 63:32 of the register. This holds in both modes.
- R4: An 8-bit write (size code 0) changes only the addressed byte. A 16-bit write (size code 1) changes only bits 15:0. All other bits of the register keep their value.
- R5: For a byte access with the prefix flag clear, register numbers 4, 5, 6 and 7 address bits 15:8 of registers 0, 1, 2 and 3 respectively. This applies to reads and writes.
- R6: For a byte access with the prefix flag set in wide mode, numbers 4 to 15 address bits 7:0 of registers 4 to 15.
- R7: Read data is combinational and zero-extended to 64 bits. A byte read gives zeros in bits 63:8, a word read in 63:16, and a doubleword read in 63:32.
- R8: When a read port and the write port hit the same register in one cycle, the read returns the value held before the write. The new value appears from the next cycle.
- R9: In legacy mode (`mode_wide`=0), some accesses are refused: the prefix flag set, a register number of 8 or more, or size code 3. A refused write changes no register and drives `wr_illegal` high in that cycle. A refused read drives its illegal output high and returns zero.
- R10: A flags write stores bits 31:0 at the clock edge. `flags_rd_data` bits 63:32 always read zero.
- R11: The two read ports work independently, each with its own register number, size and prefix flag, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_wide | input | 1 | 1 = sixteen 64-bit registers, 0 = eight 32-bit registers |
| rd0_num | input | 4 | Read port 0 register number |
| rd0_size | input | 2 | Read port 0 size: 0=8, 1=16, 2=32, 3=64 bits |
| rd0_prefix | input | 1 | Read port 0 prefix flag |
| rd0_data | output | 64 | Read port 0 data, zero-extended |
| rd0_illegal | output | 1 | Read port 0 access refused |
| rd1_num | input | 4 | Read port 1 register number |
| rd1_size | input | 2 | Read port 1 size |
| rd1_prefix | input | 1 | Read port 1 prefix flag |
| rd1_data | output | 64 | Read port 1 data, zero-extended |
| rd1_illegal | output | 1 | Read port 1 access refused |
| wr_en | input | 1 | Write strobe |
| wr_num | input | 4 | Write register number |
| wr_size | input | 2 | Write size |
| wr_prefix | input | 1 | Write prefix flag |
| wr_data | input | 64 | Write data, low bits used for narrow sizes |
| wr_illegal | output | 1 | Write refused this cycle |
| flags_wr_en | input | 1 | Flags register write strobe |
| flags_wr_data | input | 64 | Flags write data |
| flags_rd_data | output | 64 | Flags read data, upper half zero |

## Verification
The assertions check the following on every cycle:
- A 32-bit write reads back one cycle later zero-extended.
- Refused reads return zero, and legacy-mode prefix or high register numbers are always flagged.
- Byte reads have a clear upper part.
- The flags register returns the low half of its last write.
- Everything is zero after reset.

The directed scenarios cover the remaining behaviour:
- Byte and word merging into existing contents.
- The aliasing of numbers 4 to 7 onto the second byte of registers 0 to 3, and its removal by the prefix flag.
- That a refused write leaves the register untouched.
- The old value returned when a read collides with a write.
- Two read ports selecting different registers and sizes at once.

// File: rtl/regfile_alias_pkg.sv
package regfile_alias_pkg;
  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_W = 2'd1,
    SZ_D = 2'd2,
    SZ_Q = 2'd3
  } opsize_e;
endpackage

// File: rtl/rf_port_decode.sv
module rf_port_decode #(
  parameter int NUM_W    = 4,
  parameter int LEG_REGS = 8
) (
  input  logic             wide,
  input  logic             en,
  input  logic [NUM_W-1:0] num,
  input  logic [1:0]       size,
  input  logic             prefix,
  output logic [NUM_W-1:0] idx,
  output logic             hi_byte,
  output logic             illegal
);
  import regfile_alias_pkg::*;

  localparam int ALIAS_BASE = 4;
  localparam int ALIAS_TOP  = 7;

  logic in_alias;

  always_comb begin
    in_alias = (32'(num) >= ALIAS_BASE) && (32'(num) <= ALIAS_TOP);
    hi_byte  = (size == SZ_B) && !prefix && in_alias;
    idx      = hi_byte ? (num - NUM_W'(ALIAS_BASE)) : num;
    illegal  = en && !wide &&
               (prefix || (32'(num) >= LEG_REGS) || (size == SZ_Q));
  end
endmodule

// File: rtl/rf_read_lane.sv
module rf_read_lane #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] word,
  input  logic [1:0]      size,
  input  logic            hi_byte,
  input  logic            illegal,
  output logic [XLEN-1:0] data
);
  import regfile_alias_pkg::*;

  always_comb begin
    data = '0;
    if (!illegal) begin
      unique case (size)
        SZ_B:    data[7:0]  = hi_byte ? word[15:8] : word[7:0];
        SZ_W:    data[15:0] = word[15:0];
        SZ_D:    data[31:0] = word[31:0];
        default: data       = word;
      endcase
    end
  end
endmodule

// File: rtl/rf_write_merge.sv
module rf_write_merge #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] old_word,
  input  logic [XLEN-1:0] wdata,
  input  logic [1:0]      size,
  input  logic            hi_byte,
  output logic [XLEN-1:0] new_word
);
  import regfile_alias_pkg::*;

  always_comb begin
    new_word = old_word;
    unique case (size)
      SZ_B: begin
        if (hi_byte) new_word[15:8] = wdata[7:0];
        else         new_word[7:0]  = wdata[7:0];
      end
      SZ_W:    new_word[15:0] = wdata[15:0];
      SZ_D:    new_word       = {{(XLEN-32){1'b0}}, wdata[31:0]};
      default: new_word       = wdata;
    endcase
  end
endmodule

// File: rtl/regfile_alias.sv
module regfile_alias #(
  parameter int NUM_REGS = 16,
  parameter int LEG_REGS = 8,
  parameter int XLEN     = 64,
  parameter int FLAG_W   = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        mode_wide,
  input  logic [$clog2(NUM_REGS)-1:0] rd0_num,
  input  logic [1:0]                  rd0_size,
  input  logic                        rd0_prefix,
  output logic [XLEN-1:0]             rd0_data,
  output logic                        rd0_illegal,
  input  logic [$clog2(NUM_REGS)-1:0] rd1_num,
  input  logic [1:0]                  rd1_size,
  input  logic                        rd1_prefix,
  output logic [XLEN-1:0]             rd1_data,
  output logic                        rd1_illegal,
  input  logic                        wr_en,
  input  logic [$clog2(NUM_REGS)-1:0] wr_num,
  input  logic [1:0]                  wr_size,
  input  logic                        wr_prefix,
  input  logic [XLEN-1:0]             wr_data,
  output logic                        wr_illegal,
  input  logic                        flags_wr_en,
  input  logic [XLEN-1:0]             flags_wr_data,
  output logic [XLEN-1:0]             flags_rd_data
);
  localparam int NUM_W   = $clog2(NUM_REGS);
  localparam int N_RD    = 2;

  logic [XLEN-1:0]   regs_q [NUM_REGS];
  logic [FLAG_W-1:0] flags_q;

  logic [NUM_W-1:0]  rd_num    [N_RD];
  logic [1:0]        rd_size   [N_RD];
  logic              rd_prefix [N_RD];
  logic [NUM_W-1:0]  rd_idx    [N_RD];
  logic              rd_hi     [N_RD];
  logic              rd_bad    [N_RD];
  logic [XLEN-1:0]   rd_out    [N_RD];

  assign rd_num[0]    = rd0_num;
  assign rd_size[0]   = rd0_size;
  assign rd_prefix[0] = rd0_prefix;
  assign rd_num[1]    = rd1_num;
  assign rd_size[1]   = rd1_size;
  assign rd_prefix[1] = rd1_prefix;

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    rf_port_decode #(.NUM_W(NUM_W), .LEG_REGS(LEG_REGS)) dec_i (
      .wide    (mode_wide),
      .en      (1'b1),
      .num     (rd_num[p]),
      .size    (rd_size[p]),
      .prefix  (rd_prefix[p]),
      .idx     (rd_idx[p]),
      .hi_byte (rd_hi[p]),
      .illegal (rd_bad[p])
    );
    rf_read_lane #(.XLEN(XLEN)) lane_i (
      .word    (regs_q[rd_idx[p]]),
      .size    (rd_size[p]),
      .hi_byte (rd_hi[p]),
      .illegal (rd_bad[p]),
      .data    (rd_out[p])
    );
  end

  assign rd0_data    = rd_out[0];
  assign rd0_illegal = rd_bad[0];
  assign rd1_data    = rd_out[1];
  assign rd1_illegal = rd_bad[1];

  logic [NUM_W-1:0] wr_idx;
  logic             wr_hi;
  logic [XLEN-1:0]  wr_word;
  logic             wr_go;

  rf_port_decode #(.NUM_W(NUM_W), .LEG_REGS(LEG_REGS)) wdec_i (
    .wide    (mode_wide),
    .en      (wr_en),
    .num     (wr_num),
    .size    (wr_size),
    .prefix  (wr_prefix),
    .idx     (wr_idx),
    .hi_byte (wr_hi),
    .illegal (wr_illegal)
  );

  rf_write_merge #(.XLEN(XLEN)) merge_i (
    .old_word (regs_q[wr_idx]),
    .wdata    (wr_data),
    .size     (wr_size),
    .hi_byte  (wr_hi),
    .new_word (wr_word)
  );

  assign wr_go = wr_en && !wr_illegal;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs_q[r] <= '0;
      else if (wr_go && (wr_idx == NUM_W'(r)))
        regs_q[r] <= wr_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              flags_q <= '0;
    else if (flags_wr_en) flags_q <= flags_wr_data[FLAG_W-1:0];
  end

  logic flags_hi_unused;
  assign flags_hi_unused = ^flags_wr_data[XLEN-1:FLAG_W];

  assign flags_rd_data = {{(XLEN-FLAG_W){1'b0}}, flags_q};
endmodule

// File: rtl/rf_alias_chk.sv
module rf_alias_chk (
  input logic        clk,
  input logic        rst,
  input logic        mode_wide,
  input logic [3:0]  rd0_num,
  input logic [1:0]  rd0_size,
  input logic        rd0_prefix,
  input logic [63:0] rd0_data,
  input logic        rd0_illegal,
  input logic [3:0]  rd1_num,
  input logic [1:0]  rd1_size,
  input logic        rd1_prefix,
  input logic [63:0] rd1_data,
  input logic        rd1_illegal,
  input logic        wr_en,
  input logic [3:0]  wr_num,
  input logic [1:0]  wr_size,
  input logic        wr_prefix,
  input logic [63:0] wr_data,
  input logic        wr_illegal,
  input logic        flags_wr_en,
  input logic [63:0] flags_wr_data,
  input logic [63:0] flags_rd_data
);
  // R1
  reset_flags_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flags_rd_data == 64'd0));

  // R3
  zext32_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en && !wr_illegal && wr_size == 2'd2 && !rst) &&
     rd0_num == $past(wr_num) && rd0_size == 2'd3 && !rd0_illegal)
    |-> (rd0_data == {32'd0, $past(wr_data[31:0])}));

  // R7
  byte_read_zext_chk: assert property (@(posedge clk) disable iff (rst)
    (rd1_size == 2'd0) |-> (rd1_data[63:8] == 56'd0));

  // R9
  illegal_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd0_illegal |-> (rd0_data == 64'd0));

  // R9
  legacy_prefix_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_wide && rd0_prefix) |-> rd0_illegal);

  // R9
  legacy_high_num_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !mode_wide && wr_num[3]) |-> wr_illegal);

  // R10
  flags_store_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(flags_wr_en) && !$past(rst))
    |-> (flags_rd_data == {32'd0, $past(flags_wr_data[31:0])}));

  logic unused_chk;
  assign unused_chk = ^{rd1_num, rd1_prefix, rd1_illegal, wr_prefix, rd0_data[0]};
endmodule

bind regfile_alias rf_alias_chk chk_i (.*);

// File: tb/regfile_alias_tb_top.sv
`timescale 1ns/1ps
module regfile_alias_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_wide = 1'b1;
  logic [3:0]  rd0_num = '0, rd1_num = '0, wr_num = '0;
  logic [1:0]  rd0_size = '0, rd1_size = '0, wr_size = '0;
  logic        rd0_prefix = 1'b0, rd1_prefix = 1'b0, wr_prefix = 1'b0;
  logic [63:0] rd0_data, rd1_data, wr_data = '0;
  logic        rd0_illegal, rd1_illegal, wr_illegal;
  logic        wr_en = 1'b0, flags_wr_en = 1'b0;
  logic [63:0] flags_wr_data = '0, flags_rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  regfile_alias dut_i (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd0(input logic [3:0] n, input logic [1:0] s, input logic p);
    rd0_num = n; rd0_size = s; rd0_prefix = p; #1;
  endtask

  task automatic wr(input logic [3:0] n, input logic [1:0] s, input logic p,
                    input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_num = n; wr_size = s; wr_prefix = p; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    for (int r = 0; r < 16; r++) begin
      rd0(4'(r), 2'd3, 1'b0);
      chk("R1 reg zero after reset", rd0_data, 64'd0);
    end
    chk("R1 flags zero after reset", flags_rd_data, 64'd0);
  endtask

  task automatic t_wide64();
    wr(4'd15, 2'd3, 1'b0, 64'hFEDC_BA98_7654_3210);
    rd0(4'd15, 2'd3, 1'b0);
    chk("R2 64-bit reg15", rd0_data, 64'hFEDC_BA98_7654_3210);
  endtask

  task automatic t_zext32();
    wr(4'd2, 2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(4'd2, 2'd2, 1'b0, 64'hAAAA_AAAA_1234_5678);
    rd0(4'd2, 2'd3, 1'b0);
    chk("R3 32-bit write clears upper", rd0_data, 64'h0000_0000_1234_5678);
  endtask

  task automatic t_merge();
    wr(4'd3, 2'd3, 1'b0, 64'h1111_2222_3333_4444);
    wr(4'd3, 2'd1, 1'b0, 64'hFFFF_FFFF_FFFF_ABCD);
    rd0(4'd3, 2'd3, 1'b0);
    chk("R4 16-bit merge", rd0_data, 64'h1111_2222_3333_ABCD);
    wr(4'd3, 2'd0, 1'b1, 64'h0000_0000_0000_00EE);
    rd0(4'd3, 2'd3, 1'b0);
    chk("R4 8-bit low merge", rd0_data, 64'h1111_2222_3333_ABEE);
  endtask

  task automatic t_alias();
    wr(4'd5, 2'd0, 1'b0, 64'h5A);
    rd0(4'd1, 2'd3, 1'b0);
    chk("R5 num5 byte hits reg1[15:8]", rd0_data, 64'h5A00);
    rd0(4'd6, 2'd0, 1'b0);
    chk("R5 num6 byte read reg2[15:8]", rd0_data, 64'h56);
    rd0(4'd5, 2'd3, 1'b0);
    chk("R5 reg5 untouched", rd0_data, 64'd0);
  endtask

  task automatic t_prefix();
    wr(4'd5, 2'd0, 1'b1, 64'h77);
    rd0(4'd5, 2'd3, 1'b0);
    chk("R6 prefix num5 low byte reg5", rd0_data, 64'h77);
    rd0(4'd1, 2'd3, 1'b0);
    chk("R6 reg1 unchanged", rd0_data, 64'h5A00);
    wr(4'd13, 2'd0, 1'b1, 64'h99);
    rd0(4'd13, 2'd0, 1'b1);
    chk("R6 prefix num13 low byte", rd0_data, 64'h99);
  endtask

  task automatic t_readsize();
    rd0(4'd15, 2'd1, 1'b0);
    chk("R7 word read zero-ext", rd0_data, 64'h3210);
    rd0(4'd15, 2'd2, 1'b0);
    chk("R7 dword read zero-ext", rd0_data, 64'h7654_3210);
  endtask

  task automatic t_collide();
    wr(4'd7, 2'd3, 1'b0, 64'hAAAA);
    @(negedge clk);
    wr_en = 1'b1; wr_num = 4'd7; wr_size = 2'd3; wr_prefix = 1'b0; wr_data = 64'hBBBB;
    rd0(4'd7, 2'd3, 1'b0);
    chk("R8 read during write old", rd0_data, 64'hAAAA);
    @(negedge clk);
    wr_en = 1'b0; #1;
    chk("R8 new value next cycle", rd0_data, 64'hBBBB);
  endtask

  task automatic t_legacy();
    mode_wide = 1'b0;
    wr(4'd6, 2'd2, 1'b0, 64'hDEAD_BEEF);
    rd0(4'd6, 2'd2, 1'b0);
    chk("R3 legacy 32-bit write", rd0_data, 64'hDEAD_BEEF);
    @(negedge clk);
    wr_en = 1'b1; wr_num = 4'd6; wr_size = 2'd2; wr_prefix = 1'b1; wr_data = 64'h0;
    #1;
    chk("R9 prefix write flagged", {63'd0, wr_illegal}, 64'd1);
    @(negedge clk);
    wr_num = 4'd9; wr_prefix = 1'b0; wr_data = 64'h1;
    #1;
    chk("R9 num9 write flagged", {63'd0, wr_illegal}, 64'd1);
    @(negedge clk);
    wr_en = 1'b0; #1;
    rd0(4'd6, 2'd2, 1'b0);
    chk("R9 refused writes left reg6", rd0_data, 64'hDEAD_BEEF);
    rd0(4'd6, 2'd3, 1'b0);
    chk("R9 64-bit read flagged", {63'd0, rd0_illegal}, 64'd1);
    chk("R9 refused read zero", rd0_data, 64'd0);
    rd0(4'd7, 2'd0, 1'b0);
    chk("R5 legacy num7 byte reg3[15:8]", rd0_data, 64'hAB);
    chk("R9 legal byte read not flagged", {63'd0, rd0_illegal}, 64'd0);
    mode_wide = 1'b1;
  endtask

  task automatic t_flags();
    @(negedge clk);
    flags_wr_en = 1'b1; flags_wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
    #1;
    chk("R10 flags not yet written", flags_rd_data, 64'd0);
    @(negedge clk);
    flags_wr_en = 1'b0; #1;
    chk("R10 flags upper reads zero", flags_rd_data, 64'h0000_0000_FFFF_FFFF);
  endtask

  task automatic t_dual();
    rd0(4'd15, 2'd3, 1'b0);
    rd1_num = 4'd4; rd1_size = 2'd0; rd1_prefix = 1'b0; #1;
    chk("R11 port0 reg15", rd0_data, 64'hFEDC_BA98_7654_3210);
    chk("R11 port1 num4 byte reg0[15:8]", rd1_data, 64'd0);
    rd1_num = 4'd3; rd1_size = 2'd1; #1;
    chk("R11 port1 word reg3", rd1_data, 64'hABEE);
    chk("R11 port0 steady", rd0_data, 64'hFEDC_BA98_7654_3210);
  endtask

  task automatic t_rereset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    rd0(4'd15, 2'd3, 1'b0);
    chk("R1 mid-run reset reg15", rd0_data, 64'd0);
    chk("R1 mid-run reset flags", flags_rd_data, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_wide64();
    t_zext32();
    t_merge();
    t_alias();
    t_prefix();
    t_readsize();
    t_collide();
    t_legacy();
    t_flags();
    t_dual();
    t_rereset();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule